// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Aggregator

This block gathers interrupt requests from four peripheral sources into a single CPU interrupt line. The sources are a floppy-disk controller, a floppy-drive media-change event, a printer port and a hard-disk controller. One 8-bit status register holds a pending flag and an enable flag for each source. A second register holds a shared vector base that software programs.

The interrupt line is raised while any source is both pending and enabled. The CPU then runs an interrupt-acknowledge handshake. The block picks one winner by fixed priority among the sources that are pending and enabled. It returns the vector base combined with that source's 2-bit device code, and it clears the winner's pending flag.

The pending flags of the controller, printer and disk sources follow their request lines. The drive flag is an event latch: a pulse sets it, and it stays set until the drive source is acknowledged. Software reads both registers and writes them over a small byte-wide bus. A write to the status register can only change the enable half.

Top module: `irqvec_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every pending flag, every enable flag and the vector base. It also drives `irq_out`, `iack_done` and `bus_rdata` to 0.
- R2: A bus write (`bus_sel`=1, `bus_we`=1, `bus_addr`=0) loads the four enable flags from `bus_wdata[3:0]` at that clock edge. The pending flags in bits 7..4 are not changed by the write.
- R3: The status byte is laid out as follows: bit 7 = controller pending, bit 6 = drive pending, bit 5 = printer pending, bit 4 = disk pending, bit 3 = disk enable, bit 2 = controller enable, bit 1 = drive enable, bit 0 = printer enable. A bus read (`bus_sel`=1, `bus_we`=0) loads the addressed register into `bus_rdata` at the next clock edge. `bus_rdata` holds that value otherwise.
- R4: A write at `bus_addr`=1 stores `bus_wdata[7:2]` as the vector base and ignores `bus_wdata[1:0]`. A read at address 1 returns the base with bits 1..0 zero.
- R5: At every clock edge, the controller, printer and disk pending flags take the value of `req_flop_ctl`, `req_print` and `req_disk`. An acknowledge that clears a flag at that same edge overrides this.
- R6: A high `media_evt` at a clock edge sets the drive pending flag. The flag then stays set until the drive source wins an acknowledge, or until reset. If an event and a clearing acknowledge fall on the same edge, the event wins.
- R7: `irq_out` is registered. After each edge it is 1 exactly when some source had both its pending and enable flags set just before that edge.
- R8: When `iack_req` is high at an edge, `iack_done` is 1 after that edge, and 0 after an edge where `iack_req` is low. After such an edge, `iack_vector` equals the base in bits 7..2 combined with the winner's code in bits 1..0. The codes are: controller = 00, drive = 01, disk = 10, printer = 11.
- R9: The winner is the first source, among those both pending and enabled, in this order: controller, drive, printer, disk.
- R10: An acknowledge clears only the winner's pending flag, at the acknowledge edge. A level request that is still high sets its flag again at the following edge.
- R11: An acknowledge with no source both pending and enabled returns `iack_vector` = 0x18 and changes no pending flag.
- R12: A source that is pending but not enabled neither raises `irq_out` nor takes part in arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status register, 1 = vector register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| req_flop_ctl | input | 1 | Floppy controller level request |
| media_evt | input | 1 | Floppy drive media-change pulse |
| req_print | input | 1 | Printer level request |
| req_disk | input | 1 | Hard-disk controller level request |
| iack_req | input | 1 | Interrupt-acknowledge request |
| iack_done | output | 1 | Acknowledge completed, vector valid |
| iack_vector | output | 8 | Returned interrupt vector |
| irq_out | output | 1 | Merged interrupt request to the CPU |

## Verification
The bench sweeps all 256 combinations of pending and enable flags. For each combination it checks the interrupt line, the status readback, the acknowledge vector and the flags after the acknowledge. A priority chain in the wrong order, or device codes that follow the priority order, would return the wrong low vector bits whenever two sources compete. A status write that overwrote the pending half would show up in the readback taken just after the enables are rewritten. An event latch that let a coinciding acknowledge win would lose the drive flag. A design that cleared flags on an empty acknowledge, or returned anything other than 0x18 for it, would fail the combinations where nothing is both pending and enabled.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;

  // Source index equals acknowledge priority rank (0 wins).
  localparam int NSRC = 4;
  localparam int SRC_CTL = 0;
  localparam int SRC_MED = 1;
  localparam int SRC_PRN = 2;
  localparam int SRC_DSK = 3;

  // Sources whose pending flag is an event latch rather than a level.
  localparam logic [NSRC-1:0] EVT_MASK = 4'b0010;

  // Bit position of each source's pending flag in the status byte.
  function automatic int pend_pos(input int idx);
    case (idx)
      SRC_CTL: return 7;
      SRC_MED: return 6;
      SRC_PRN: return 5;
      default: return 4;
    endcase
  endfunction

  // Bit position of each source's enable flag in the status byte.
  function automatic int en_pos(input int idx);
    case (idx)
      SRC_CTL: return 2;
      SRC_MED: return 1;
      SRC_PRN: return 0;
      default: return 3;
    endcase
  endfunction

  // Device code placed in vector bits 1..0.
  function automatic logic [1:0] dev_code(input int idx);
    case (idx)
      SRC_CTL: return 2'b00;
      SRC_MED: return 2'b01;
      SRC_PRN: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/irqvec_status.sv
module irqvec_status
  import irqvec_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] EVT = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] en
);

  always_ff @(posedge clk) begin
    if (rst)        en <= '0;
    else if (en_we) en <= en_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EVT[i]) begin : g_evt
      // Event latch: a set pulse beats a same-edge clear.
      always_ff @(posedge clk) begin
        if (rst)            pend[i] <= 1'b0;
        else if (src_in[i]) pend[i] <= 1'b1;
        else if (clr[i])    pend[i] <= 1'b0;
      end
    end else begin : g_lvl
      // Level follower: an acknowledge clears for one edge.
      always_ff @(posedge clk) begin
        if (rst)         pend[i] <= 1'b0;
        else if (clr[i]) pend[i] <= 1'b0;
        else             pend[i] <= src_in[i];
      end
    end
  end

endmodule

// File: rtl/irqvec_arb.sv
module irqvec_arb
  import irqvec_pkg::*;
#(
  parameter int N = NSRC,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_VEC = 8'h18,
  localparam int BASE_W = DATA_W - 2
) (
  input  logic [N-1:0]      act,
  input  logic [BASE_W-1:0] base,
  output logic [N-1:0]      grant,
  output logic [DATA_W-1:0] vector
);

  logic [N:0] seen;
  logic [1:0] code;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = act[i] & ~seen[i];
    assign seen[i+1] = seen[i] | act[i];
  end

  always_comb begin
    code = 2'b00;
    for (int i = 0; i < N; i++)
      if (grant[i]) code = code | dev_code(i);
  end

  assign vector = seen[N] ? {base, code} : IDLE_VEC;

endmodule

// File: rtl/irqvec_regbus.sv
module irqvec_regbus #(
  parameter int DATA_W = 8,
  localparam int BASE_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              st_we,
  output logic [3:0]        st_wdata,
  output logic [BASE_W-1:0] vec_base
);

  logic wr, rd;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign st_we    = wr & ~bus_addr;
  assign st_wdata = bus_wdata[3:0];

  always_ff @(posedge clk) begin
    if (rst)                vec_base <= '0;
    else if (wr & bus_addr) vec_base <= bus_wdata[DATA_W-1:2];
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= bus_addr ? {vec_base, 2'b00} : status_q;
  end

endmodule

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_VEC = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              req_flop_ctl,
  input  logic              media_evt,
  input  logic              req_print,
  input  logic              req_disk,
  input  logic              iack_req,
  output logic              iack_done,
  output logic [DATA_W-1:0] iack_vector,
  output logic              irq_out
);

  localparam int BASE_W = DATA_W - 2;

  logic [NSRC-1:0]   pend, en, act, grant, en_wdata, src_in, clr;
  logic [DATA_W-1:0] status_q, arb_vec;
  logic [BASE_W-1:0] vec_base;
  logic              st_we;
  logic [3:0]        st_wdata;

  assign src_in[SRC_CTL] = req_flop_ctl;
  assign src_in[SRC_MED] = media_evt;
  assign src_in[SRC_PRN] = req_print;
  assign src_in[SRC_DSK] = req_disk;

  always_comb begin
    status_q = '0;
    for (int i = 0; i < NSRC; i++) begin
      status_q[pend_pos(i)] = pend[i];
      status_q[en_pos(i)]   = en[i];
      en_wdata[i]           = st_wdata[en_pos(i)];
    end
  end

  assign act = pend & en;
  assign clr = iack_req ? grant : '0;

  irqvec_regbus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status_q(status_q), .bus_rdata(bus_rdata),
    .st_we(st_we), .st_wdata(st_wdata), .vec_base(vec_base)
  );

  irqvec_status #(.N(NSRC), .EVT(EVT_MASK)) u_stat (
    .clk(clk), .rst(rst),
    .en_we(st_we), .en_wdata(en_wdata),
    .src_in(src_in), .clr(clr),
    .pend(pend), .en(en)
  );

  irqvec_arb #(.N(NSRC), .DATA_W(DATA_W), .IDLE_VEC(IDLE_VEC)) u_arb (
    .act(act), .base(vec_base), .grant(grant), .vector(arb_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out     <= 1'b0;
      iack_done   <= 1'b0;
      iack_vector <= '0;
    end else begin
      irq_out   <= |act;
      iack_done <= iack_req;
      if (iack_req) iack_vector <= arb_vec;
    end
  end

endmodule

// File: rtl/irqvec_ctrl_chk.sv
module irqvec_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_VEC = 8'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              media_evt,
  input logic              iack_req,
  input logic              iack_done,
  input logic [DATA_W-1:0] iack_vector,
  input logic              irq_out,
  input logic [3:0]        pend,
  input logic [3:0]        en,
  input logic [3:0]        act,
  input logic [3:0]        grant,
  input logic [DATA_W-3:0] vec_base
);

  assert_enable_load_R2: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_we && !bus_addr |=>
      en == $past({bus_wdata[3], bus_wdata[0], bus_wdata[1], bus_wdata[2]}));

  assert_base_load_R4: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_we && bus_addr |=> vec_base == $past(bus_wdata[DATA_W-1:2]));

  assert_media_sets_R6: assert property (@(posedge clk) disable iff (rst)
    media_evt |=> pend[1]);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (act != 4'b0) |=> irq_out);

  assert_irq_drop_R12: assert property (@(posedge clk) disable iff (rst)
    (act == 4'b0) |=> !irq_out);

  assert_done_R8: assert property (@(posedge clk) disable iff (rst)
    iack_req |=> iack_done);

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_drive_code_R9: assert property (@(posedge clk) disable iff (rst)
    iack_req && act[1] && !act[0] |=> iack_vector[1:0] == 2'b01);

  assert_ctl_clear_R10: assert property (@(posedge clk) disable iff (rst)
    iack_req && act[0] |=> !pend[0] && iack_vector == {$past(vec_base), 2'b00});

  assert_idle_vec_R11: assert property (@(posedge clk) disable iff (rst)
    iack_req && act == 4'b0 |=> iack_vector == IDLE_VEC);

endmodule

bind irqvec_ctrl irqvec_ctrl_chk #(.DATA_W(DATA_W), .IDLE_VEC(IDLE_VEC)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .media_evt(media_evt), .iack_req(iack_req),
  .iack_done(iack_done), .iack_vector(iack_vector), .irq_out(irq_out),
  .pend(pend), .en(en), .act(act), .grant(grant), .vec_base(vec_base)
);

// File: tb/tb_irqvec_ctrl.sv
module tb_irqvec_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_we = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       req_flop_ctl = 0, media_evt = 0, req_print = 0, req_disk = 0;
  logic       iack_req = 0;
  logic       iack_done;
  logic [7:0] iack_vector;
  logic       irq_out;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irqvec_ctrl dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_flop_ctl(req_flop_ctl), .media_evt(media_evt),
    .req_print(req_print), .req_disk(req_disk),
    .iack_req(iack_req), .iack_done(iack_done),
    .iack_vector(iack_vector), .irq_out(irq_out)
  );

  // Source index order: 0 controller, 1 drive, 2 printer, 3 disk.
  function automatic logic [7:0] stat_byte(input logic [3:0] p, input logic [3:0] e);
    return {p[0], p[1], p[2], p[3], e[3], e[0], e[1], e[2]};
  endfunction

  function automatic logic [7:0] en_byte(input logic [3:0] e);
    return {4'b0000, e[3], e[0], e[1], e[2]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    nchk++;
    if (act_v !== exp_v) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_bus();
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; iack_req = 0;
  endtask

  task automatic do_reset();
    idle_bus();
    req_flop_ctl = 0; media_evt = 0; req_print = 0; req_disk = 0;
    rst = 1; cyc(); rst = 0;
  endtask

  task automatic rd(input logic a);
    bus_sel = 1; bus_we = 0; bus_addr = a; cyc(); idle_bus();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; cyc(); idle_bus();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [3:0] p, e, a, p_after;
    logic [5:0] vb;
    logic [7:0] exp_vec;
    int win;

    cyc(); cyc();
    chk("R1 irq_out in reset", {7'b0, irq_out}, 8'h00);
    chk("R1 iack_done in reset", {7'b0, iack_done}, 8'h00);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst = 0;
    rd(0); chk("R1 status after reset", bus_rdata, 8'h00);
    rd(1); chk("R1 vector base after reset", bus_rdata, 8'h00);

    for (int c = 0; c < 256; c++) begin
      p  = c[3:0];
      e  = c[7:4];
      a  = p & e;
      vb = 6'((c * 37 + 5) & 63);
      do_reset();

      // enables written in the same edge the requests are sampled
      req_flop_ctl = p[0]; media_evt = p[1]; req_print = p[2]; req_disk = p[3];
      bus_sel = 1; bus_we = 1; bus_addr = 0; bus_wdata = en_byte(e);
      cyc();
      media_evt = 0;
      wr(1, {vb, 2'b11});
      chk("R7 R12 irq_out level", {7'b0, irq_out}, {7'b0, |a});
      rd(0); chk("R3 R5 R6 status readback", bus_rdata, stat_byte(p, e));
      rd(1); chk("R4 vector readback", bus_rdata, {vb, 2'b00});

      win = -1;
      for (int i = 0; i < 4; i++) if (win < 0 && a[i]) win = i;
      case (win)
        0: exp_vec = {vb, 2'b00};
        1: exp_vec = {vb, 2'b01};
        2: exp_vec = {vb, 2'b11};
        3: exp_vec = {vb, 2'b10};
        default: exp_vec = 8'h18;
      endcase

      iack_req = 1; cyc(); iack_req = 0;
      chk("R8 iack_done", {7'b0, iack_done}, 8'h01);
      chk("R8 R9 R11 R12 iack_vector", iack_vector, exp_vec);

      p_after = p;
      if (win >= 0) p_after[win] = 1'b0;
      rd(0);
      chk("R10 R11 status after ack", bus_rdata, stat_byte(p_after, e));
      chk("R8 iack_done drops", {7'b0, iack_done}, 8'h00);

      p_after = p;
      if (win == 1) p_after[1] = 1'b0;
      rd(0);
      chk("R10 level re-sets, latch stays clear", bus_rdata, stat_byte(p_after, e));

      wr(0, 8'hF0 | en_byte(~e));
      rd(0);
      chk("R2 pending kept on status write", bus_rdata, stat_byte(p_after, ~e));
    end

    // Drive event latch against acknowledge on the same edge.
    do_reset();
    wr(0, 8'h02);
    media_evt = 1; cyc(); media_evt = 0;
    rd(0); chk("R6 event latched", bus_rdata, 8'h42);
    media_evt = 1; iack_req = 1; cyc(); media_evt = 0; iack_req = 0;
    chk("R8 drive vector", iack_vector, 8'h01);
    rd(0); chk("R6 event beats clear", bus_rdata, 8'h42);
    iack_req = 1; cyc(); iack_req = 0;
    chk("R9 drive vector again", iack_vector, 8'h01);
    rd(0); chk("R10 latch cleared", bus_rdata, 8'h02);
    chk("R7 irq_out off", {7'b0, irq_out}, 8'h00);
    iack_req = 1; cyc(); iack_req = 0;
    chk("R11 empty ack", iack_vector, 8'h18);

    // Printer outranks disk although its code is numerically larger.
    do_reset();
    wr(1, 8'h80);
    wr(0, 8'h09);
    req_print = 1; req_disk = 1; cyc(); cyc();
    iack_req = 1; cyc(); iack_req = 0;
    chk("R9 printer before disk", iack_vector, 8'h83);
    req_print = 0; cyc();
    iack_req = 1; cyc(); iack_req = 0;
    chk("R9 disk after printer drops", iack_vector, 8'h82);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule